// File: doc/BRIEF.md
# Flash Command Sequence Guard

This block sits on the register bus between the processor and a flash program/erase engine. Software builds each command in three ordered steps. The first step is one write into the flash array window, which supplies the target address and data. The second is one write of the command code into the command register. The third is a write to the status register that sets the buffer-empty bit, and this write launches the command. The guard holds the captured address, data and code, and gives the engine a one-cycle launch pulse. It keeps the buffer-empty bit clear until the engine reports completion.

Any departure from the legal order sets a sticky access-error flag. This covers a missing clock-divider setting, repeated steps, stray register accesses, illegal or debug-restricted codes, cancelling a partly built command, and a stop request during an operation. While the flag is set, no new command can be built. Software clears the flag by writing 1 to its status bit. An error raised during the build phase sends the sequencer back to idle and discards everything captured. A stop request during a running operation also pulses an abort to the engine.

Register map: index 0 is the clock divider (write bits [DIV_W-1:0]; read bit 7 = divider has been written). Index 1 is status: bit 7 buffer-empty, bit 6 command-done, bit 4 access error. Index 2 is the command code. Index 3 is unused and reads zero. The register index is taken from the low two address bits when `bus_arr` is 0.

Top module: `flash_seq_guard`

## Requirements
- R1: After reset, status reads 0xC0 (buffer-empty and done set, error clear), the divider register reads 0x00, and no launch occurs.
- R2: An array-window write before the divider register has ever been written sets the error bit (status 0xD0). Once the divider is written, it reads back with bit 7 set.
- R3: The sequence array write, command write, then status write with bit 7 = 1 raises `eng_launch` for exactly one cycle after the launching write. `eng_cmd`, `eng_addr` and `eng_data` show the captured values. Status reads 0x00 until `eng_done`, and 0xC0 after it.
- R4: The error bit is sticky. While it is set, array and command writes are ignored and no launch can happen. A status write with bit 4 = 1 clears it.
- R5: A second array write before launch sets the error bit.
- R6: A command write with no preceding array write, or a second command write, sets the error bit.
- R7: After the array write, a write to any control register other than the command register sets the error bit, and the divider value is left unchanged.
- R8: Only the codes 0x05, 0x20, 0x25, 0x40 and 0x41 are accepted. Any other code sets the error bit.
- R9: After the command write, any control register read, any status write with bit 7 = 0 (cancel), or any array write sets the error bit without launching.
- R10: An array write while an operation runs (buffer-empty clear) sets the error bit. It does not abort the operation.
- R11: A stop request while an operation runs pulses `eng_abort` for one cycle, sets the error bit and sets buffer-empty, leaving done clear (status 0x90).
- R12: With `secured` = 1, codes 0x20, 0x25 and 0x40 written with `bus_dbg` = 1 set the error bit. Codes 0x05 and 0x41 are accepted from the debug path. Restricted codes are accepted when not secured or when written without `bus_dbg`.
- R13: After any error, the captured step is discarded. A launch write issued from idle does nothing, and a new command needs a fresh array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_arr | input | 1 | 1 = flash array window, 0 = control register |
| bus_dbg | input | 1 | Access comes from the debug path |
| bus_addr | input | ADDR_W | Array address, or register index in bits [1:0] |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Control register read data (combinational) |
| secured | input | 1 | Device is secured |
| stop_req | input | 1 | Stop-mode entry request |
| eng_done | input | 1 | Engine finished the running operation |
| eng_launch | output | 1 | One-cycle command start pulse |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_cmd | output | 8 | Captured command code |
| eng_addr | output | ADDR_W | Captured array address |
| eng_data | output | DATA_W | Captured array data |

## Verification
The bench builds the guard with ADDR_W = 12, DATA_W = 8 and DIV_W = 6. The narrower address makes the captured address on `eng_addr` easy to compare across several distinct addresses. The 6-bit divider keeps the divider-ready flag in bit 7 separate from the value, so a blocked divider write during a build shows up as an unchanged read. With the default data width, every status encoding checked in the requirements sits in one byte. Each violation is driven from the exact sequencer state it applies to, and normal launches follow it, so both the sticky flag and the discard of captured steps are visible at the ports.

// File: rtl/fcg_pkg.sv
// Shared constants and types for the flash command sequence guard.
// Assumes an 8-bit command code and at least 8 bits of register data.
package fcg_pkg;
    localparam int REG_W = 2;
    localparam logic [REG_W-1:0] REG_DIV  = 2'd0;
    localparam logic [REG_W-1:0] REG_STAT = 2'd1;
    localparam logic [REG_W-1:0] REG_CMD  = 2'd2;

    localparam int ST_BE   = 7;
    localparam int ST_DONE = 6;
    localparam int ST_ERR  = 4;
    localparam int DIV_FLAG = 7;

    localparam int CODE_W  = 8;
    localparam int N_LEGAL = 5;
    localparam int N_RESTR = 3;
    localparam logic [CODE_W-1:0] LEGAL_CODES [N_LEGAL] = '{8'h05, 8'h20, 8'h25, 8'h40, 8'h41};
    localparam logic [CODE_W-1:0] RESTR_CODES [N_RESTR] = '{8'h20, 8'h25, 8'h40};

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_DATA = 2'd1,
        SQ_CMD  = 2'd2,
        SQ_RUN  = 2'd3
    } seq_t;
endpackage

// File: rtl/fcg_cmd_check.sv
// Command code classifier: flags whether a code is one of the legal
// codes and whether it is barred from the debug path while secured.
// Purely combinational; assumes code tables from fcg_pkg.
module fcg_cmd_check
    import fcg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              legal,
    output logic              restricted
);
    logic [N_LEGAL-1:0] hit_legal;
    logic [N_RESTR-1:0] hit_restr;

    // One comparator per legal code.
    for (genvar i = 0; i < N_LEGAL; i++) begin : g_legal
        assign hit_legal[i] = (code == LEGAL_CODES[i]);
    end

    // One comparator per debug-restricted code.
    for (genvar j = 0; j < N_RESTR; j++) begin : g_restr
        assign hit_restr[j] = (code == RESTR_CODES[j]);
    end

    assign legal      = |hit_legal;
    assign restricted = |hit_restr;
endmodule

// File: rtl/fcg_ctl_regs.sv
// Control register file: clock divider with its written flag, the
// sticky access-error flag, the command-done flag and the read mux.
// Assumes the sequencer qualifies writes (ctl_ok) and reports errors.
module fcg_ctl_regs
    import fcg_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_ok,
    input  logic [REG_W-1:0]  reg_idx,
    input  logic              stat_wr,
    input  logic              err_wbit,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              err_set,
    input  logic              op_start,
    input  logic              op_end,
    input  logic              running,
    input  logic [CODE_W-1:0] cmd_q,
    output logic              err_q,
    output logic              div_set,
    output logic [7:0]        rd8
);
    logic [DIV_W-1:0] div_q;
    logic             done_q;

    // Divider value and its written-once flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            div_set <= 1'b0;
        end else if (ctl_ok && reg_idx == REG_DIV) begin
            div_q   <= div_wdata;
            div_set <= 1'b1;
        end
    end

    // Sticky error flag; a new error outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (err_set)
            err_q <= 1'b1;
        else if (stat_wr && err_wbit)
            err_q <= 1'b0;
    end

    // Command-done flag: cleared at launch, set when the engine finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b1;
        else if (op_start)
            done_q <= 1'b0;
        else if (op_end)
            done_q <= 1'b1;
    end

    // Read data mux for the control registers.
    always_comb begin
        rd8 = '0;
        unique case (reg_idx)
            REG_DIV: begin
                rd8[DIV_W-1:0] = div_q;
                rd8[DIV_FLAG]  = div_set;
            end
            REG_STAT: begin
                rd8[ST_BE]   = !running;
                rd8[ST_DONE] = done_q;
                rd8[ST_ERR]  = err_q;
            end
            REG_CMD: rd8 = cmd_q;
            default: rd8 = '0;
        endcase
    end

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(stat_wr && err_wbit)) |=> err_q);

    assert_div_flag_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_set |=> div_set);
endmodule

// File: rtl/fcg_seq_fsm.sv
// Command build sequencer: tracks array write, command write and
// launch, detects every protocol violation and drives the engine.
// Assumes one bus access per cycle and a level stop request.
module fcg_seq_fsm
    import fcg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_arr,
    input  logic              bus_dbg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              secured,
    input  logic              stop_req,
    input  logic              eng_done,
    input  logic              err_q,
    input  logic              div_set,
    input  logic              code_legal,
    input  logic              code_restricted,
    output logic              err_set,
    output logic              ctl_ok,
    output logic              op_start,
    output logic              op_end,
    output logic              running,
    output logic              in_build,
    output logic              launch,
    output logic              abort,
    output logic [CODE_W-1:0] cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    seq_t state, state_d;
    logic ctl_acc, ctl_wr, arr_wr, is_stat, is_cmd, cmd_wr, cmd_bad;
    logic cap_arr, cap_cmd, kill, build_err;

    // Access decode.
    always_comb begin
        ctl_acc = bus_req && !bus_arr;
        ctl_wr  = ctl_acc && bus_we;
        arr_wr  = bus_req && bus_arr && bus_we;
        is_stat = (bus_addr[REG_W-1:0] == REG_STAT);
        is_cmd  = (bus_addr[REG_W-1:0] == REG_CMD);
        cmd_wr  = ctl_wr && is_cmd;
        cmd_bad = !code_legal || (secured && bus_dbg && code_restricted);
    end

    // Next-state and violation detection.
    always_comb begin
        state_d  = state;
        err_set  = 1'b0;
        cap_arr  = 1'b0;
        cap_cmd  = 1'b0;
        op_start = 1'b0;
        op_end   = 1'b0;
        kill     = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (!err_q) begin
                    if (arr_wr) begin
                        if (!div_set) err_set = 1'b1;
                        else begin
                            cap_arr = 1'b1;
                            state_d = SQ_DATA;
                        end
                    end else if (cmd_wr) begin
                        err_set = 1'b1;
                    end
                end
            end
            SQ_DATA: begin
                if (arr_wr) err_set = 1'b1;
                else if (cmd_wr) begin
                    if (cmd_bad) err_set = 1'b1;
                    else begin
                        cap_cmd = 1'b1;
                        state_d = SQ_CMD;
                    end
                end else if (ctl_wr) err_set = 1'b1;
            end
            SQ_CMD: begin
                if (ctl_wr && is_stat && bus_wdata[ST_BE]) begin
                    op_start = 1'b1;
                    state_d  = SQ_RUN;
                end else if (arr_wr || ctl_acc) begin
                    err_set = 1'b1;
                end
            end
            SQ_RUN: begin
                if (arr_wr || cmd_wr) err_set = 1'b1;
                if (stop_req) begin
                    kill    = 1'b1;
                    err_set = 1'b1;
                    state_d = SQ_IDLE;
                end else if (eng_done) begin
                    op_end  = 1'b1;
                    state_d = SQ_IDLE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
        build_err = err_set && (state == SQ_DATA || state == SQ_CMD);
        if (build_err) state_d = SQ_IDLE;
    end

    // A control write is committed only when it is not a violation.
    assign ctl_ok   = ctl_wr && !err_set && (state == SQ_IDLE || state == SQ_RUN);
    assign running  = (state == SQ_RUN);
    assign in_build = (state == SQ_DATA || state == SQ_CMD);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_d;
    end

    // Engine strobes, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch <= 1'b0;
            abort  <= 1'b0;
        end else begin
            launch <= op_start;
            abort  <= kill;
        end
    end

    // Captured address, data and code; discarded on a build error.
    always_ff @(posedge clk) begin
        if (!rst_n || build_err) begin
            addr_q <= '0;
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (cap_arr) begin
                addr_q <= bus_addr;
                data_q <= bus_wdata;
            end
            if (cap_cmd) cmd_q <= bus_wdata[CODE_W-1:0];
        end
    end

    assert_launch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    assert_illegal_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DATA && cmd_wr && !code_legal) |=> (state == SQ_IDLE && !launch));

    assert_secure_debug_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DATA && cmd_wr && secured && bus_dbg && code_restricted)
        |=> (state == SQ_IDLE && err_q));

    assert_cancel_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_CMD && ctl_wr && is_stat && !bus_wdata[ST_BE]) |=> (!launch && err_q));
endmodule

// File: rtl/flash_seq_guard.sv
// Top of the flash command sequence guard: connects the sequencer,
// the command code classifier and the control register file.
// Assumes DATA_W >= 8 and DIV_W <= 7.
module flash_seq_guard
    import fcg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_arr,
    input  logic              bus_dbg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              secured,
    input  logic              stop_req,
    input  logic              eng_done,
    output logic              eng_launch,
    output logic              eng_abort,
    output logic [7:0]        eng_cmd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [DATA_W-1:0] eng_data
);
    logic err_q, div_set, code_legal, code_restricted;
    logic err_set, ctl_ok, op_start, op_end, running, in_build;
    logic stat_wr;
    logic [7:0] rd8;

    assign stat_wr = bus_req && bus_we && !bus_arr && (bus_addr[REG_W-1:0] == REG_STAT);

    fcg_cmd_check u_code (
        .code       (bus_wdata[CODE_W-1:0]),
        .legal      (code_legal),
        .restricted (code_restricted)
    );

    fcg_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_req         (bus_req),
        .bus_we          (bus_we),
        .bus_arr         (bus_arr),
        .bus_dbg         (bus_dbg),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .secured         (secured),
        .stop_req        (stop_req),
        .eng_done        (eng_done),
        .err_q           (err_q),
        .div_set         (div_set),
        .code_legal      (code_legal),
        .code_restricted (code_restricted),
        .err_set         (err_set),
        .ctl_ok          (ctl_ok),
        .op_start        (op_start),
        .op_end          (op_end),
        .running         (running),
        .in_build        (in_build),
        .launch          (eng_launch),
        .abort           (eng_abort),
        .cmd_q           (eng_cmd),
        .addr_q          (eng_addr),
        .data_q          (eng_data)
    );

    fcg_ctl_regs #(.DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_ok    (ctl_ok),
        .reg_idx   (bus_addr[REG_W-1:0]),
        .stat_wr   (stat_wr),
        .err_wbit  (bus_wdata[ST_ERR]),
        .div_wdata (bus_wdata[DIV_W-1:0]),
        .err_set   (err_set),
        .op_start  (op_start),
        .op_end    (op_end),
        .running   (running),
        .cmd_q     (eng_cmd),
        .err_q     (err_q),
        .div_set   (div_set),
        .rd8       (rd8)
    );

    assign bus_rdata = DATA_W'(rd8);

    assert_abort_sets_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> err_q);

    assert_launch_clears_be_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_launch |-> running);

    assert_build_error_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_build |-> !err_q);
endmodule

// File: tb/tb_flash_seq_guard.sv
module tb_flash_seq_guard;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 0, bus_we = 0, bus_arr = 0, bus_dbg = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic secured = 0, stop_req = 0, eng_done = 0;
    logic eng_launch, eng_abort;
    logic [7:0] eng_cmd;
    logic [ADDR_W-1:0] eng_addr;
    logic [DATA_W-1:0] eng_data;

    int checks = 0;
    int errors = 0;
    int n_launch = 0;
    int n_abort = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_seq_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_arr(bus_arr), .bus_dbg(bus_dbg), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .secured(secured),
        .stop_req(stop_req), .eng_done(eng_done), .eng_launch(eng_launch),
        .eng_abort(eng_abort), .eng_cmd(eng_cmd), .eng_addr(eng_addr),
        .eng_data(eng_data)
    );

    // Strobe counters sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && eng_launch) n_launch++;
        if (rst_n && eng_abort)  n_abort++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_req = 0; bus_we = 0; bus_arr = 0; bus_dbg = 0;
    endtask

    task automatic wr_arr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_arr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic wr_reg(input int idx, input logic [DATA_W-1:0] d, input bit dbg);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_arr = 0; bus_dbg = dbg;
        bus_addr = ADDR_W'(idx); bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd_reg(input int idx, output logic [DATA_W-1:0] v);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_arr = 0; bus_addr = ADDR_W'(idx);
        #1 v = bus_rdata;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic exp_stat(input logic [7:0] e, input string tag);
        logic [DATA_W-1:0] v;
        rd_reg(1, v);
        chk(v == e, tag, v, e);
    endtask

    task automatic clear_err();
        wr_reg(1, 8'h10, 0);
    endtask

    task automatic finish_op();
        @(negedge clk); eng_done = 1;
        @(negedge clk); eng_done = 0;
    endtask

    // Full legal command; checks launch, captured values and flags.
    task automatic t_good(input logic [7:0] c, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input bit dbg, input string tag);
        wr_arr(a, d);
        wr_reg(2, c, dbg);
        wr_reg(1, 8'h80, 0);
        chk(eng_launch == 1'b1, {tag, " launch high"}, eng_launch, 1);
        chk(eng_cmd == c, {tag, " cmd"}, eng_cmd, c);
        chk(eng_addr == a && eng_data == d, {tag, " addr/data"}, {eng_addr, eng_data}, {a, d});
        @(negedge clk);
        chk(eng_launch == 1'b0, {tag, " launch single cycle R3"}, eng_launch, 0);
        exp_stat(8'h00, {tag, " running status R3"});
        finish_op();
        exp_stat(8'hC0, {tag, " done status R3"});
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        exp_stat(8'hC0, "R1 reset status");
        rd_reg(0, v);
        chk(v == 8'h00, "R1 divider reset", v, 0);
        chk(n_launch == 0 && eng_launch == 0, "R1 no launch", n_launch, 0);
    endtask

    task automatic t_no_divider();
        logic [DATA_W-1:0] v;
        wr_arr(12'h100, 8'hAA);
        exp_stat(8'hD0, "R2 array write before divider");
        clear_err();
        exp_stat(8'hC0, "R4 clear by writing 1");
        wr_reg(0, 8'h05, 0);
        rd_reg(0, v);
        chk(v == 8'h85, "R2 divider written flag", v, 8'h85);
    endtask

    task automatic t_sticky();
        int base;
        wr_reg(2, 8'h20, 0);
        exp_stat(8'hD0, "R6 command write with no array write");
        base = n_launch;
        wr_arr(12'h010, 8'h11);
        wr_reg(2, 8'h20, 0);
        wr_reg(1, 8'h80, 0);
        @(negedge clk);
        chk(n_launch == base, "R4 no launch while error set", n_launch, base);
        exp_stat(8'hD0, "R4 error stays set");
        clear_err();
        exp_stat(8'hC0, "R4 cleared");
    endtask

    task automatic t_second_arr();
        int base;
        wr_arr(12'h020, 8'h22);
        wr_arr(12'h021, 8'h23);
        exp_stat(8'hD0, "R5 second array write");
        clear_err();
        base = n_launch;
        wr_reg(1, 8'h80, 0);
        @(negedge clk);
        chk(n_launch == base, "R13 launch from idle ignored", n_launch, base);
        chk(eng_addr == '0, "R13 captured address discarded", eng_addr, 0);
    endtask

    task automatic t_second_cmd();
        int base;
        wr_arr(12'h030, 8'h33);
        wr_reg(2, 8'h20, 0);
        wr_reg(2, 8'h20, 0);
        exp_stat(8'hD0, "R6 second command write");
        clear_err();
        base = n_launch;
        wr_reg(1, 8'h80, 0);
        @(negedge clk);
        chk(n_launch == base, "R13 no launch after discarded command", n_launch, base);
    endtask

    task automatic t_stray();
        logic [DATA_W-1:0] v;
        wr_arr(12'h040, 8'h44);
        wr_reg(0, 8'h09, 0);
        exp_stat(8'hD0, "R7 divider write after array write");
        rd_reg(0, v);
        chk(v == 8'h85, "R7 divider unchanged", v, 8'h85);
        clear_err();
        wr_arr(12'h041, 8'h45);
        wr_reg(3, 8'h00, 0);
        exp_stat(8'hD0, "R7 unused register write after array write");
        clear_err();
        wr_arr(12'h042, 8'h46);
        wr_reg(1, 8'h10, 0);
        exp_stat(8'hD0, "R7 status write after array write");
        clear_err();
    endtask

    task automatic t_illegal();
        logic [7:0] bad [4] = '{8'h00, 8'h30, 8'hFF, 8'h21};
        for (int i = 0; i < 4; i++) begin
            int base;
            base = n_launch;
            wr_arr(12'h050, 8'h55);
            wr_reg(2, bad[i], 0);
            wr_reg(1, 8'h80, 0);
            @(negedge clk);
            chk(n_launch == base, "R8 illegal code not launched", n_launch, base);
            exp_stat(8'hD0, "R8 illegal code error");
            clear_err();
        end
    endtask

    task automatic t_after_cmd();
        logic [DATA_W-1:0] v;
        int base;
        base = n_launch;
        wr_arr(12'h060, 8'h66);
        wr_reg(2, 8'h20, 0);
        rd_reg(1, v);
        exp_stat(8'hD0, "R9 status read after command");
        clear_err();
        wr_arr(12'h061, 8'h67);
        wr_reg(2, 8'h20, 0);
        wr_reg(1, 8'h00, 0);
        exp_stat(8'hD0, "R9 cancel with buffer-empty 0");
        clear_err();
        wr_arr(12'h062, 8'h68);
        wr_reg(2, 8'h40, 0);
        rd_reg(0, v);
        exp_stat(8'hD0, "R9 divider read after command");
        clear_err();
        wr_arr(12'h063, 8'h69);
        wr_reg(2, 8'h40, 0);
        wr_arr(12'h064, 8'h6A);
        exp_stat(8'hD0, "R9 array write after command");
        clear_err();
        chk(n_launch == base, "R9 nothing launched", n_launch, base);
    endtask

    task automatic t_busy_arr();
        int ab;
        ab = n_abort;
        wr_arr(12'h070, 8'h77);
        wr_reg(2, 8'h20, 0);
        wr_reg(1, 8'h80, 0);
        wr_arr(12'h071, 8'h78);
        exp_stat(8'h10, "R10 array write while running");
        chk(n_abort == ab, "R10 no abort", n_abort, ab);
        finish_op();
        exp_stat(8'hD0, "R10 operation still completes");
        clear_err();
    endtask

    task automatic t_stop();
        int ab;
        ab = n_abort;
        wr_arr(12'h080, 8'h88);
        wr_reg(2, 8'h41, 0);
        wr_reg(1, 8'h80, 0);
        @(negedge clk); stop_req = 1;
        @(negedge clk); stop_req = 0;
        chk(eng_abort == 1'b1, "R11 abort pulse", eng_abort, 1);
        @(negedge clk);
        chk(eng_abort == 1'b0 && n_abort == ab + 1, "R11 abort single cycle", n_abort, ab + 1);
        exp_stat(8'h90, "R11 status after stop");
        clear_err();
        exp_stat(8'h80, "R11 cleared, done still clear");
    endtask

    task automatic t_secure();
        int base;
        logic [7:0] restr [3] = '{8'h20, 8'h25, 8'h40};
        secured = 1;
        for (int i = 0; i < 3; i++) begin
            base = n_launch;
            wr_arr(12'h090, 8'h99);
            wr_reg(2, restr[i], 1);
            wr_reg(1, 8'h80, 0);
            @(negedge clk);
            chk(n_launch == base, "R12 restricted debug code blocked", n_launch, base);
            exp_stat(8'hD0, "R12 secured debug error");
            clear_err();
        end
        t_good(8'h05, 12'h0A0, 8'hA1, 1, "R12 blank check from debug");
        t_good(8'h41, 12'h0A1, 8'hA2, 1, "R12 mass erase from debug");
        t_good(8'h20, 12'h0A2, 8'hA3, 0, "R12 restricted code from normal path");
        secured = 0;
        t_good(8'h40, 12'h0A3, 8'hA4, 1, "R12 debug when not secured");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_no_divider();
        t_good(8'h20, 12'hABC, 8'h5A, 0, "R3 byte program");
        t_good(8'h05, 12'h001, 8'hFF, 0, "R8 legal 05");
        t_good(8'h25, 12'hFFF, 8'h00, 0, "R8 legal 25");
        t_good(8'h40, 12'h800, 8'h3C, 0, "R8 legal 40");
        t_good(8'h41, 12'h123, 8'hC3, 0, "R8 legal 41");
        t_sticky();
        t_second_arr();
        t_second_cmd();
        t_stray();
        t_illegal();
        t_after_cmd();
        t_busy_arr();
        t_stop();
        t_good(8'h20, 12'h321, 8'h12, 0, "R13 fresh command after errors");
        t_secure();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule